// File: doc/BRIEF.md
# Cross-Domain Packet Occupancy Counter

This block counts the complete packets held in a dual-clock FIFO. The logic that writes a packet into the FIFO raises a one-cycle completion pulse on the write clock once the last word of a packet is stored. The logic that reads a packet raises a similar pulse on its own, unrelated read clock once the packet has left. Packets can have any length, so the count is in packets and not in words.

The count register and all of its update logic run on the write clock only. A read pulse flips a toggle register in the read domain. That level then passes through a multi-flop synchronizer in the write domain. An edge detector at the end of the synchronizer turns each toggle change into exactly one write-clock decrement strobe. The block drives a flag that is high whenever at least one complete packet is present.

An increment at the top of the range, or a decrement at zero, leaves the count unchanged and sets an error flag. The error flag stays set until the write-side reset.

Top module: `pkt_occ_counter`

## Requirements
- R1: While `wr_rst` is high at a write-clock edge, that edge clears `pkt_count` to 0, `pkt_avail` to 0 and `occ_err` to 0. While `rd_rst` is high at a read-clock edge, that edge clears the read-side toggle.
- R2: A single-cycle `wr_pkt_done` pulse with no decrement in the same cycle raises `pkt_count` by one. The new value is visible after the write-clock edge that samples the pulse.
- R3: Read pulses must be at least four read-clock cycles apart. Each single-cycle `rd_pkt_done` pulse lowers `pkt_count` by exactly one, no later than the fourth write-clock edge after the read-clock edge that samples it, and never more than once.
- R4: `pkt_avail` is 1 when `pkt_count` is greater than zero and 0 when `pkt_count` is zero.
- R5: If a write pulse and a synchronized read strobe land in the same write-clock cycle, `pkt_count` does not change.
- R6: An increment while `pkt_count` equals `MAX_PKTS` (15 by default) leaves the count at `MAX_PKTS` and sets `occ_err`.
- R7: A decrement while `pkt_count` is zero leaves the count at zero and sets `occ_err`.
- R8: Once set, `occ_err` stays high through any later pulses on either side, and only a write-side reset clears it.
- R9: When write and read pulses are interleaved at unrelated times from both clocks, the count in range, the settled count equals the starting count plus the number of write pulses minus the number of read pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; the counter runs on this clock |
| wr_rst | input | 1 | Synchronous active-high reset for the write domain |
| wr_pkt_done | input | 1 | One-cycle pulse: a whole packet has been written |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_rst | input | 1 | Synchronous active-high reset for the read domain |
| rd_pkt_done | input | 1 | One-cycle pulse: a whole packet has been read |
| pkt_count | output | $clog2(MAX_PKTS+1) | Number of complete packets held |
| pkt_avail | output | 1 | High while at least one complete packet is held |
| occ_err | output | 1 | Sticky flag: an increment at full or a decrement at empty was dropped |

## Verification
An increment from the write side and a decrement strobe that comes out of the synchronizer can fall on the same write-clock edge. The bench cannot see the strobe, so it starts from a count of one, issues a read pulse, and then places a write pulse at each of seven offsets from zero to six write cycles. One of those offsets is certain to coincide with the strobe. The judgement uses only the ports: after each offset, once both events have settled, the count must be back at one with no error. A design that let either side win would leave it at two or zero.

// File: rtl/pkt_occ_pkg.sv
package pkt_occ_pkg;

    // Operation applied to the occupancy register in one write-clock cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_UP   = 2'd1,
        OCC_DOWN = 2'd2
    } occ_op_e;

    // Raw requests that arrive in the write domain during one cycle.
    typedef struct packed {
        logic up;
        logic down;
    } occ_req_t;

    // Count width that holds 0 .. max_pkts.
    function automatic int unsigned occ_width(input int unsigned max_pkts);
        return (max_pkts < 1) ? 1 : $clog2(max_pkts + 1);
    endfunction

    // Opposite requests in one cycle cancel out.
    function automatic occ_op_e occ_decode(input occ_req_t r);
        occ_op_e op;
        unique case ({r.up, r.down})
            2'b10:   op = OCC_UP;
            2'b01:   op = OCC_DOWN;
            default: op = OCC_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/occ_toggle_src.sv
// Read-domain half of the pulse crossing: one level change per pulse.
module occ_toggle_src (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tog <= 1'b0;
        end else if (pulse) begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/occ_toggle_dst.sv
// Write-domain half: synchronizer chain plus an edge stage.
module occ_toggle_dst #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic strobe
);

    localparam int unsigned CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= tog_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // The last synchronized stage differs from the edge stage exactly once per toggle.
    assign strobe = chain[CHAIN_LEN-1] ^ chain[CHAIN_LEN-2];

endmodule

// File: rtl/occ_updown.sv
// Saturating up/down packet counter with a sticky range error.
module occ_updown
    import pkt_occ_pkg::*;
#(
    parameter int unsigned MAX_PKTS = 15,
    parameter int unsigned CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  occ_op_e          op,
    output logic [CNT_W-1:0] count,
    output logic             nonzero,
    output logic             err
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_PKTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            unique case (op)
                OCC_UP: begin
                    if (count == CNT_TOP) err <= 1'b1;
                    else                  count <= count + 1'b1;
                end
                OCC_DOWN: begin
                    if (count == '0) err <= 1'b1;
                    else             count <= count - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign nonzero = (count != '0);

endmodule

// File: rtl/pkt_occ_counter.sv
module pkt_occ_counter
    import pkt_occ_pkg::*;
#(
    parameter  int unsigned MAX_PKTS    = 15,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W       = occ_width(MAX_PKTS)
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_pkt_done,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_pkt_done,
    output logic [CNT_W-1:0] pkt_count,
    output logic             pkt_avail,
    output logic             occ_err
);

    logic     rd_toggle;
    logic     dn_stb;
    occ_req_t req;
    occ_op_e  op;

    occ_toggle_src u_src (
        .clk   (rd_clk),
        .rst   (rd_rst),
        .pulse (rd_pkt_done),
        .tog   (rd_toggle)
    );

    occ_toggle_dst #(.SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .tog_in (rd_toggle),
        .strobe (dn_stb)
    );

    always_comb begin
        req.up   = wr_pkt_done;
        req.down = dn_stb;
        op       = occ_decode(req);
    end

    occ_updown #(.MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W)) u_cnt (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .op      (op),
        .count   (pkt_count),
        .nonzero (pkt_avail),
        .err     (occ_err)
    );

endmodule

// File: rtl/pkt_occ_checker.sv
module pkt_occ_checker #(
    parameter int unsigned MAX_PKTS = 15,
    parameter int unsigned CNT_W    = 4
) (
    input logic             wr_clk,
    input logic             wr_rst,
    input logic             rd_clk,
    input logic             rd_rst,
    input logic             wr_pkt_done,
    input logic             rd_pkt_done,
    input logic             dn_stb,
    input logic             rd_toggle,
    input logic [CNT_W-1:0] pkt_count,
    input logic             pkt_avail,
    input logic             occ_err
);

    localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_PKTS);

    // R2
    up_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_pkt_done && !dn_stb && pkt_count != CMAX)
        |=> pkt_count == CNT_W'($past(pkt_count) + 1'b1));

    // R3
    down_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (dn_stb && !wr_pkt_done && pkt_count != '0)
        |=> pkt_count == CNT_W'($past(pkt_count) - 1'b1));

    // R3
    toggle_flip_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_pkt_done |=> rd_toggle != $past(rd_toggle));

    // R3
    toggle_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_pkt_done |=> $stable(rd_toggle));

    // R4
    avail_rise_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!pkt_avail && !wr_pkt_done) |=> !pkt_avail);

    // R5
    same_cycle_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_pkt_done && dn_stb) |=> $stable(pkt_count));

    // R6
    full_drop_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_pkt_done && !dn_stb && pkt_count == CMAX)
        |=> (pkt_count == CMAX && occ_err));

    // R7
    empty_drop_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (dn_stb && !wr_pkt_done && pkt_count == '0)
        |=> (pkt_count == '0 && occ_err));

    // R8
    err_sticky_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        occ_err |=> occ_err);

endmodule

bind pkt_occ_counter pkt_occ_checker #(.MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst      (wr_rst),
    .rd_clk      (rd_clk),
    .rd_rst      (rd_rst),
    .wr_pkt_done (wr_pkt_done),
    .rd_pkt_done (rd_pkt_done),
    .dn_stb      (dn_stb),
    .rd_toggle   (rd_toggle),
    .pkt_count   (pkt_count),
    .pkt_avail   (pkt_avail),
    .occ_err     (occ_err)
);

// File: tb/sim_pkt_occ_counter.sv
module sim_pkt_occ_counter;

    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 13;
    localparam int MAXP       = 15;
    localparam int CW         = $clog2(MAXP + 1);

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst = 1'b1;
    logic          rd_rst = 1'b1;
    logic          wr_pkt_done = 1'b0;
    logic          rd_pkt_done = 1'b0;
    logic [CW-1:0] pkt_count;
    logic          pkt_avail;
    logic          occ_err;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    cnt;
        bit    err;
        string req;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2.0) rd_clk = ~rd_clk;

    pkt_occ_counter #(.MAX_PKTS(MAXP), .SYNC_STAGES(2)) u0 (
        .wr_clk      (wr_clk),
        .wr_rst      (wr_rst),
        .wr_pkt_done (wr_pkt_done),
        .rd_clk      (rd_clk),
        .rd_rst      (rd_rst),
        .rd_pkt_done (rd_pkt_done),
        .pkt_count   (pkt_count),
        .pkt_avail   (pkt_avail),
        .occ_err     (occ_err)
    );

    // Monitor: pops one expectation per write-clock low phase and compares.
    initial begin
        forever begin
            @(negedge wr_clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(pkt_count) != e.cnt || pkt_avail != (e.cnt != 0) || occ_err != e.err) begin
                    errors++;
                    $display("FAIL %s: count=%0d avail=%0b err=%0b expected count=%0d avail=%0b err=%0b",
                             e.req, pkt_count, pkt_avail, occ_err, e.cnt, (e.cnt != 0), e.err);
                end
            end
        end
    end

    task automatic expect_state(input int cnt, input bit err, input string req);
        exp_t e;
        e.cnt = cnt; e.err = err; e.req = req;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        wr_rst = 1'b1; rd_rst = 1'b1;
        repeat (5) @(negedge wr_clk);
        @(negedge rd_clk); rd_rst = 1'b0;
        @(negedge wr_clk); wr_rst = 1'b0;
        model = 0;
    endtask

    task automatic wr_pulse();
        @(negedge wr_clk); wr_pkt_done = 1'b1;
        @(negedge wr_clk); wr_pkt_done = 1'b0;
    endtask

    // Pulse sampled on one read edge, then a gap of four read cycles.
    task automatic rd_pulse();
        @(negedge rd_clk); rd_pkt_done = 1'b1;
        @(posedge rd_clk); #1 rd_pkt_done = 1'b0;
        repeat (4) @(posedge rd_clk);
    endtask

    task automatic settle();
        repeat (10) @(negedge wr_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_state(0, 1'b0, "R1 reset state");

        // R2 each write pulse counts up after one edge
        for (int i = 1; i <= 3; i++) begin
            wr_pulse();
            model++;
            expect_state(model, 1'b0, "R2 single-edge increment");
        end

        // R3 latency bound and a single decrement per read pulse
        @(negedge rd_clk); rd_pkt_done = 1'b1;
        @(posedge rd_clk); #1 rd_pkt_done = 1'b0;
        repeat (4) @(posedge wr_clk);
        model--;
        expect_state(model, 1'b0, "R3 decrement within four write edges");
        settle();
        expect_state(model, 1'b0, "R3 no second decrement");

        // R4 flag follows count down to zero
        rd_pulse(); settle(); model--;
        expect_state(model, 1'b0, "R4 flag high at count 1");
        rd_pulse(); settle(); model--;
        expect_state(model, 1'b0, "R4 flag low at count 0");

        // R7 decrement at empty
        rd_pulse(); settle();
        expect_state(0, 1'b1, "R7 decrement at zero dropped");

        // R8 error stays through later pulses
        wr_pulse(); model = 1;
        expect_state(1, 1'b1, "R8 error sticky after increment");
        rd_pulse(); settle(); model = 0;
        expect_state(0, 1'b1, "R8 error sticky after decrement");

        // R1 write reset clears the error
        do_reset();
        expect_state(0, 1'b0, "R1 reset clears error");

        // R6 increment at full
        for (int i = 0; i < MAXP; i++) wr_pulse();
        model = MAXP;
        expect_state(MAXP, 1'b0, "R6 reaches maximum");
        wr_pulse();
        expect_state(MAXP, 1'b1, "R6 increment at maximum dropped");
        do_reset();

        // R5 sweep the write pulse across the strobe position
        wr_pulse(); model = 1;
        for (int off = 0; off <= 6; off++) begin
            @(negedge rd_clk); rd_pkt_done = 1'b1;
            @(posedge rd_clk); #1 rd_pkt_done = 1'b0;
            repeat (off) @(posedge wr_clk);
            wr_pulse();
            settle();
            expect_state(1, 1'b0, $sformatf("R5 coincidence sweep offset %0d", off));
        end

        // R9 concurrent random traffic from both clocks
        for (int round = 0; round < 3; round++) begin
            int ups, downs;
            ups   = (round == 0) ? 6 : (round == 1) ? 3 : 5;
            downs = (round == 0) ? 6 : (round == 1) ? 5 : 2;
            if (round == 0) begin
                for (int i = 0; i < 6; i++) wr_pulse();
                model = 7;
            end
            fork
                begin
                    for (int i = 0; i < ups; i++) begin
                        repeat ($urandom_range(1, 5)) @(negedge wr_clk);
                        wr_pulse();
                    end
                end
                begin
                    for (int i = 0; i < downs; i++) begin
                        repeat ($urandom_range(0, 4)) @(negedge rd_clk);
                        rd_pulse();
                    end
                end
            join
            settle();
            model = model + ups - downs;
            expect_state(model, 1'b0, $sformatf("R9 mixed traffic round %0d", round));
        end

        repeat (3) @(negedge wr_clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule